// File: doc/BRIEF.md
# Register State Transfer Engine

This block moves the architectural register state of one execution engine into the register file of the other engine when execution hands over between them. The two engines are a wide out-of-order engine with a renamed physical file and a narrow in-order engine whose file is indexed directly by architectural register number. A transfer lets execution switch engines at a fine grain without a long software-visible copy.

One transfer runs as a three-stage pipeline. First, a map stage turns an architectural index into a source address. Toward the in-order engine this goes through a rename-table read port; toward the out-of-order engine the address is the architectural index itself. Second, a read stage fetches the value from the source file. Third, a write stage stores it into the destination file. Registers enter the pipeline in ascending order, one per cycle. Commits from the engine being drained may continue during the transfer. A commit to a register that has already entered the pipeline marks it for another copy. The block reports completion only when every copy reflects the last committed value.

Top module: `reg_xfer_engine`

## Requirements
- R1: With `dir_i`=0 (out-of-order to in-order), after `done_o` every in-order file entry a holds the out-of-order physical entry that the rename table maps a to.
- R2: With `dir_i`=1 (in-order to out-of-order), after `done_o` every out-of-order physical entry a (a below the architectural count) holds in-order entry a. The rename table is not used.
- R3: Each register passes through map, read and write stages on consecutive cycles. With no commit during the transfer, `done_o` is high on the 35th rising edge after the edge that samples `start_i` (architectural count 32, plus 3).
- R4: Registers 0 through 31 are written to the destination in ascending order, on consecutive cycles, one per cycle.
- R5: Commits to the source engine during a transfer never leave a stale value: at `done_o` the destination matches the latest committed source state.
- R6: A commit to a register whose map stage has already run, or runs in the same cycle, causes exactly one extra copy of it. This includes a commit arriving in the cycle completion would otherwise be declared. `done_o` rises only when no copy is pending and the pipeline is empty.
- R7: `done_o` is a one-cycle pulse, once per transfer.
- R8: `start_i` is ignored while a transfer is in progress: an extra pulse produces no additional writes or completions.
- R9: Only the destination file's write enable is ever asserted, and neither is asserted when no transfer is running.
- R10: After reset `done_o` and both write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transfer (sampled when idle) |
| dir_i | input | 1 | 0: out-of-order to in-order, 1: in-order to out-of-order |
| done_o | output | 1 | One-cycle completion pulse |
| commit_en_i | input | 1 | Source engine commits a register this cycle |
| commit_areg_i | input | 5 | Architectural index of the commit |
| rat_addr_o | output | 5 | Rename-table read index |
| rat_data_i | input | 7 | Physical register from the rename table (same cycle) |
| big_rd_addr_o | output | 7 | Out-of-order file read address |
| big_rd_data_i | input | 32 | Out-of-order file read data (same cycle) |
| little_rd_addr_o | output | 5 | In-order file read address |
| little_rd_data_i | input | 32 | In-order file read data (same cycle) |
| big_wr_en_o | output | 1 | Out-of-order file write enable |
| big_wr_addr_o | output | 7 | Out-of-order file write address |
| big_wr_data_o | output | 32 | Out-of-order file write data |
| little_wr_en_o | output | 1 | In-order file write enable |
| little_wr_addr_o | output | 5 | In-order file write address |
| little_wr_data_o | output | 32 | In-order file write data |

## Verification
A source commit and the map stage of the same register can fall in the same cycle. A commit can also land in the cycle when completion would otherwise be declared. The bench forces both with directed commits: register 5 in the cycle it is mapped, register 6 in that same cycle, and register 0 in the cycle before completion. It then judges the outcome by the count of destination writes (32 or 33) and by comparing every destination entry with a bench model of the source. Randomly timed commits in both directions cover the general overlap.

// File: rtl/reg_xfer_pkg.sv
package reg_xfer_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_SCAN = 2'd1,
    XS_FIX  = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/reg_xfer_pick.sv
module reg_xfer_pick #(
  parameter int N  = 32,
  parameter int AW = 5
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [AW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = AW'(i);
    end
  end
endmodule

// File: rtl/reg_xfer_ctrl.sv
module reg_xfer_ctrl
  import reg_xfer_pkg::*;
#(
  parameter int NUM_AREG = 32,
  parameter int AW       = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dir_i,
  input  logic          commit_en_i,
  input  logic [AW-1:0] commit_areg_i,
  input  logic          pipe_busy_i,
  output logic          issue_o,
  output logic [AW-1:0] issue_areg_o,
  output logic          issue_scan_o,
  output logic          dir_o,
  output logic          done_o
);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] LAST = CW'(NUM_AREG - 1);

  xfer_state_e         state_q;
  logic [CW-1:0]       idx_q;
  logic [NUM_AREG-1:0] pend_q, pend_d;
  logic                dir_q, done_q;
  logic                pick_any, mark, finish;
  logic [AW-1:0]       pick_idx;

  reg_xfer_pick #(.N(NUM_AREG), .AW(AW)) u_pick (
    .req_i(pend_q), .any_o(pick_any), .idx_o(pick_idx)
  );

  always_comb begin
    issue_o      = 1'b0;
    issue_scan_o = 1'b0;
    issue_areg_o = idx_q[AW-1:0];
    if (state_q == XS_SCAN) begin
      issue_o      = 1'b1;
      issue_scan_o = 1'b1;
    end else if (state_q == XS_FIX) begin
      issue_o      = pick_any;
      issue_areg_o = pick_idx;
    end
    // register already mapped (or mapped now) -> copy again later
    mark = commit_en_i &&
           ((state_q == XS_SCAN && {1'b0, commit_areg_i} <= idx_q) || state_q == XS_FIX);
    pend_d = pend_q;
    if (state_q == XS_FIX && pick_any) pend_d[pick_idx] = 1'b0;
    if (mark) pend_d[commit_areg_i] = 1'b1;
    finish = (state_q == XS_FIX) && !pick_any && !pipe_busy_i && !commit_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
      idx_q   <= '0;
      pend_q  <= '0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      pend_q <= pend_d;
      unique case (state_q)
        XS_IDLE: if (start_i) begin
          state_q <= XS_SCAN;
          idx_q   <= '0;
          dir_q   <= dir_i;
          pend_q  <= '0;
        end
        XS_SCAN: begin
          idx_q <= idx_q + CW'(1);
          if (idx_q == LAST) state_q <= XS_FIX;
        end
        XS_FIX: if (finish) state_q <= XS_IDLE;
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign dir_o  = dir_q;
  assign done_o = done_q;

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (pend_q == '0) && !pipe_busy_i);
  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == XS_SCAN && idx_q != LAST && start_i) |=> (idx_q == $past(idx_q) + CW'(1)));
endmodule

// File: rtl/reg_xfer_pipe.sv
module reg_xfer_pipe #(
  parameter int AW = 5,
  parameter int PW = 7,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_i,
  input  logic          issue_i,
  input  logic [AW-1:0] issue_areg_i,
  input  logic          issue_scan_i,
  output logic          busy_o,
  output logic [AW-1:0] rat_addr_o,
  input  logic [PW-1:0] rat_data_i,
  output logic [PW-1:0] big_rd_addr_o,
  input  logic [DW-1:0] big_rd_data_i,
  output logic [AW-1:0] little_rd_addr_o,
  input  logic [DW-1:0] little_rd_data_i,
  output logic          big_wr_en_o,
  output logic [PW-1:0] big_wr_addr_o,
  output logic [DW-1:0] big_wr_data_o,
  output logic          little_wr_en_o,
  output logic [AW-1:0] little_wr_addr_o,
  output logic [DW-1:0] little_wr_data_o
);
  logic          s2_v, s2_scan, s3_v, s3_scan;
  logic [AW-1:0] s2_areg, s3_areg;
  logic [PW-1:0] s2_src, s1_src;
  logic [DW-1:0] s3_data;

  // stage 1: map
  assign rat_addr_o = issue_areg_i;
  assign s1_src     = dir_i ? PW'(issue_areg_i) : rat_data_i;

  // stage 2: read
  assign big_rd_addr_o    = s2_src;
  assign little_rd_addr_o = s2_src[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v <= 1'b0; s2_scan <= 1'b0; s2_areg <= '0; s2_src <= '0;
      s3_v <= 1'b0; s3_scan <= 1'b0; s3_areg <= '0; s3_data <= '0;
    end else begin
      s2_v    <= issue_i;
      s2_scan <= issue_i && issue_scan_i;
      s2_areg <= issue_areg_i;
      s2_src  <= s1_src;
      s3_v    <= s2_v;
      s3_scan <= s2_scan;
      s3_areg <= s2_areg;
      s3_data <= dir_i ? little_rd_data_i : big_rd_data_i;
    end
  end

  // stage 3: write
  assign big_wr_en_o      = s3_v && dir_i;
  assign big_wr_addr_o    = PW'(s3_areg);
  assign big_wr_data_o    = s3_data;
  assign little_wr_en_o   = s3_v && !dir_i;
  assign little_wr_addr_o = s3_areg;
  assign little_wr_data_o = s3_data;
  assign busy_o           = s2_v || s3_v;

  assert_identity_map_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_v && dir_i) |-> (s2_src == PW'(s2_areg)));
  assert_stage_chain_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_v |=> s3_v && (s3_areg == $past(s2_areg)));
  assert_ascending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s3_v && s3_scan && $past(s3_v && s3_scan)) |-> (s3_areg == $past(s3_areg) + AW'(1)));
  assert_one_dest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(big_wr_en_o && little_wr_en_o));
endmodule

// File: rtl/reg_xfer_engine.sv
module reg_xfer_engine #(
  parameter int NUM_AREG = 32,
  parameter int BIG_PHYS = 128,
  parameter int DW       = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        dir_i,
  output logic                        done_o,
  input  logic                        commit_en_i,
  input  logic [$clog2(NUM_AREG)-1:0] commit_areg_i,
  output logic [$clog2(NUM_AREG)-1:0] rat_addr_o,
  input  logic [$clog2(BIG_PHYS)-1:0] rat_data_i,
  output logic [$clog2(BIG_PHYS)-1:0] big_rd_addr_o,
  input  logic [DW-1:0]               big_rd_data_i,
  output logic [$clog2(NUM_AREG)-1:0] little_rd_addr_o,
  input  logic [DW-1:0]               little_rd_data_i,
  output logic                        big_wr_en_o,
  output logic [$clog2(BIG_PHYS)-1:0] big_wr_addr_o,
  output logic [DW-1:0]               big_wr_data_o,
  output logic                        little_wr_en_o,
  output logic [$clog2(NUM_AREG)-1:0] little_wr_addr_o,
  output logic [DW-1:0]               little_wr_data_o
);
  localparam int AW = $clog2(NUM_AREG);
  localparam int PW = $clog2(BIG_PHYS);

  logic          issue, issue_scan, dir, pipe_busy;
  logic [AW-1:0] issue_areg;

  reg_xfer_ctrl #(.NUM_AREG(NUM_AREG), .AW(AW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .dir_i,
    .commit_en_i, .commit_areg_i,
    .pipe_busy_i (pipe_busy),
    .issue_o     (issue),
    .issue_areg_o(issue_areg),
    .issue_scan_o(issue_scan),
    .dir_o       (dir),
    .done_o
  );

  reg_xfer_pipe #(.AW(AW), .PW(PW), .DW(DW)) u_pipe (
    .clk_i, .rst_ni,
    .dir_i       (dir),
    .issue_i     (issue),
    .issue_areg_i(issue_areg),
    .issue_scan_i(issue_scan),
    .busy_o      (pipe_busy),
    .rat_addr_o, .rat_data_i,
    .big_rd_addr_o, .big_rd_data_i,
    .little_rd_addr_o, .little_rd_data_i,
    .big_wr_en_o, .big_wr_addr_o, .big_wr_data_o,
    .little_wr_en_o, .little_wr_addr_o, .little_wr_data_o
  );

  assert_quiet_reset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !done_o && !big_wr_en_o && !little_wr_en_o);
endmodule

// File: tb/tb_reg_xfer_engine.sv
module tb_reg_xfer_engine;
  localparam int NA = 32;
  localparam int NP = 128;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start = 0, dir = 0, done, commit_en = 0;
  logic [4:0]  commit_areg = '0, rat_addr, little_rd_addr, little_wr_addr;
  logic [6:0]  rat_data, big_rd_addr, big_wr_addr;
  logic [31:0] big_rd_data, little_rd_data, big_wr_data, little_wr_data;
  logic [31:0] commit_data = '0;
  logic        big_wr_en, little_wr_en;

  logic [31:0] bphys [NP];
  logic [31:0] lfile [NA];
  logic [6:0]  rat   [NA];
  logic        cur_dir = 0;

  int checks = 0, errors = 0;
  int nwr, ord_err, wrong_wr, done_cnt, mcyc, last_cyc;
  bit mon_on = 0, finished = 0;

  reg_xfer_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_i(dir), .done_o(done),
    .commit_en_i(commit_en), .commit_areg_i(commit_areg),
    .rat_addr_o(rat_addr), .rat_data_i(rat_data),
    .big_rd_addr_o(big_rd_addr), .big_rd_data_i(big_rd_data),
    .little_rd_addr_o(little_rd_addr), .little_rd_data_i(little_rd_data),
    .big_wr_en_o(big_wr_en), .big_wr_addr_o(big_wr_addr), .big_wr_data_o(big_wr_data),
    .little_wr_en_o(little_wr_en), .little_wr_addr_o(little_wr_addr), .little_wr_data_o(little_wr_data)
  );

  assign rat_data       = rat[rat_addr];
  assign big_rd_data    = bphys[big_rd_addr];
  assign little_rd_data = lfile[little_rd_addr];

  // file models: source commits remap (out-of-order side) or overwrite
  always @(posedge clk) begin
    logic [6:0] np;
    if (commit_en) begin
      if (!cur_dir) begin
        np = (rat[commit_areg] < 7'd32) ? 7'(commit_areg) + 7'd32 : 7'(commit_areg);
        rat[commit_areg] <= np;
        bphys[np] <= commit_data;
      end else lfile[commit_areg] <= commit_data;
    end
    if (big_wr_en)    bphys[big_wr_addr]    <= big_wr_data;
    if (little_wr_en) lfile[little_wr_addr] <= little_wr_data;
  end

  always @(negedge clk) if (mon_on) begin
    if (done) done_cnt++;
    if ((cur_dir == 0 && big_wr_en) || (cur_dir == 1 && little_wr_en)) wrong_wr++;
    else if (big_wr_en || little_wr_en) begin
      if (nwr < NA) begin
        if (int'(cur_dir ? big_wr_addr : 7'(little_wr_addr)) != nwr) ord_err++;
        if (nwr > 0 && mcyc != last_cyc + 1) ord_err++;
        last_cyc = mcyc;
      end
      nwr++;
    end
    mcyc++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_lat();
    return NA + 3;
  endfunction

  task automatic check_contents(input string tag);
    for (int a = 0; a < NA; a++) begin
      if (!cur_dir) chk(lfile[a] == bphys[rat[a]], tag, lfile[a], bphys[rat[a]]);
      else          chk(bphys[a] == lfile[a], tag, bphys[a], lfile[a]);
    end
    if (cur_dir) for (int a = 0; a < NA; a++) rat[a] = 7'(a);
  endtask

  // one transfer; dc_cyc/dc_reg: directed commit; pct: random commit rate
  task automatic do_xfer(input logic d, input int pct, input int dc_cyc, input int dc_reg,
                         input int xstart_cyc, output int lat);
    int c;
    nwr = 0; ord_err = 0; wrong_wr = 0; done_cnt = 0; mcyc = 0; last_cyc = 0;
    cur_dir = d; dir = d; start = 1; mon_on = 1;
    @(negedge clk);
    start = 0;
    c = 0;
    while (!done && c < 2000) begin
      commit_en = 0;
      start = (c == xstart_cyc);
      if (c == dc_cyc) begin
        commit_en = 1; commit_areg = 5'(dc_reg); commit_data = $urandom;
      end else if (pct > 0 && c < 60 && ($urandom % 100) < pct) begin
        commit_en = 1; commit_areg = 5'($urandom % NA); commit_data = $urandom;
      end
      @(negedge clk);
      c++;
    end
    commit_en = 0; start = 0;
    lat = c;
    @(negedge clk);
    chk(!done, "R7 done pulse width", done, 0);
    repeat (3) @(negedge clk);
    mon_on = 0;
    chk(done_cnt == 1, "R7 one done per transfer", done_cnt, 1);
    chk(wrong_wr == 0, "R9 wrong file written", wrong_wr, 0);
    chk(ord_err == 0, "R4 ascending one per cycle", ord_err, 0);
  endtask

  initial begin
    int lat, s;
    s = $urandom(32'h1A2B);
    for (int i = 0; i < NP; i++) bphys[i] = $urandom;
    for (int i = 0; i < NA; i++) begin lfile[i] = $urandom; rat[i] = 7'(i); end
    repeat (3) @(negedge clk);
    chk(!done && !big_wr_en && !little_wr_en, "R10 reset outputs", {done, big_wr_en, little_wr_en}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !big_wr_en && !little_wr_en, "R10 after reset", {done, big_wr_en, little_wr_en}, 0);
    for (int i = 0; i < NA; i++) rat[i] = 7'(i) + ((i % 2) ? 7'd32 : 7'd0);

    // out-of-order -> in-order, quiet
    do_xfer(0, 0, -1, 0, -1, lat);
    chk(lat == exp_lat(), "R3 latency big->little", lat, exp_lat());
    chk(nwr == NA, "R4 write count", nwr, NA);
    check_contents("R1 big->little contents");

    // in-order -> out-of-order, quiet
    for (int i = 0; i < NA; i++) lfile[i] = $urandom;
    do_xfer(1, 0, -1, 0, -1, lat);
    chk(lat == exp_lat(), "R3 latency little->big", lat, exp_lat());
    check_contents("R2 little->big contents");

    // commit to register 5 in the cycle it is mapped
    do_xfer(0, 0, 5, 5, -1, lat);
    chk(nwr == NA + 1, "R6 recopy same-cycle commit", nwr, NA + 1);
    check_contents("R5 same-cycle commit contents");

    // commit to register 6 while 5 is mapped: no recopy needed
    do_xfer(0, 0, 5, 6, -1, lat);
    chk(nwr == NA, "R6 no recopy for unmapped reg", nwr, NA);
    check_contents("R5 early commit contents");

    // commit in the cycle completion would be declared
    do_xfer(1, 0, exp_lat() - 1, 0, -1, lat);
    chk(nwr == NA + 1, "R6 commit at completion", nwr, NA + 1);
    chk(lat > exp_lat(), "R6 done delayed", lat, exp_lat() + 1);
    check_contents("R5 late commit contents");

    // extra start mid-transfer
    do_xfer(0, 0, -1, 0, 7, lat);
    chk(nwr == NA, "R8 extra start ignored", nwr, NA);
    chk(lat == exp_lat(), "R8 latency unchanged", lat, exp_lat());
    check_contents("R8 contents");

    // random commits, alternating direction
    for (int t = 0; t < 8; t++) begin
      do_xfer(logic'(t % 2), 25, -1, 0, -1, lat);
      chk(nwr >= NA, "R5 random write count", nwr, NA);
      check_contents("R5 random commit contents");
    end

    repeat (5) @(negedge clk);
    chk(!big_wr_en && !little_wr_en && !done, "R9 idle quiet", {big_wr_en, little_wr_en}, 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule